// File: doc/BRIEF.md
# Transmit Buffer Interrupt Status Unit

This block holds the bytes a host queues for transmission and reports the state of that queue, together with a few radio-side conditions, through one 8-bit status word and one active-high interrupt line. The host pushes bytes through a write port. The serializer drains them in arrival order through a pop port that shows the oldest byte ahead of the pop.

Three status flags follow the buffer's fill level with no delay. A sticky error flag records an underrun or an overflow, and only the buffer-clear control removes it. The transmit-complete and transmit-error flags are set by single-cycle pulses from the packet engine, and a read of the status word clears them. The oscillator-stable and low-voltage bits are registered copies of their inputs. The low-voltage bit is forced to 0 while the power monitor is off. An 8-bit enable register picks which status bits may raise the interrupt.

Top module: `txbuf_irq_status`

## Requirements
- R1: After reset, `stat_q` reads 8'hB8 (bits 7, 5, 4 and 3 set), `en_q` is 0 and `irq` is low.
- R2: Popped bytes appear on `pop_data` in the order they were written. `pop_data` shows the oldest held byte before it is popped. A pop on an empty buffer is ignored.
- R3: Bit 5 is 1 whenever 15 or fewer bytes are held. Bit 4 is 1 whenever 8 or fewer are held. Bit 3 is 1 whenever none are held. All three follow the fill level in the cycle after the write or pop that changes it.
- R4: A write while 16 bytes are held and no pop is taken is dropped, so the buffer contents stay unchanged, and bit 2 (buffer error) is set after that edge.
- R5: While the buffer is empty and `pkt_remain` is non-zero, bit 2 is set after the next edge.
- R6: Bit 2 stays set until `buf_clr` is high. `buf_clr` empties the buffer and clears bit 2 after a single edge.
- R7: A pulse on `done_evt` sets bit 1 and a pulse on `fail_evt` sets bit 0 after the edge. A cycle with `stat_rd` high clears both after that edge.
- R8: When `stat_rd` and an event pulse fall in the same cycle, the flag of that event is set after the edge.
- R9: `irq` is high exactly when some bit of `stat_q` and the same bit of `en_q` are both 1. Each status bit keeps its value whatever its enable bit holds. `en_we` loads `en_q` from `en_wdata`.
- R10: Bit 6 reads `vbat_low` registered one edge earlier while `mon_on` is high, and 0 while `mon_on` is low. Bit 7 reads `osc_ok` registered one edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Push `wr_data` into the buffer |
| wr_data | input | 8 | Byte to push |
| pop_en | input | 1 | Drain the oldest byte |
| pop_data | output | 8 | Oldest held byte |
| pkt_remain | input | 8 | Bytes still owed to the current packet |
| osc_ok | input | 1 | Oscillator has settled |
| mon_on | input | 1 | Power monitor enabled |
| vbat_low | input | 1 | Supply below threshold |
| done_evt | input | 1 | Transmit-complete pulse |
| fail_evt | input | 1 | Transmit-error pulse |
| stat_rd | input | 1 | Status read strobe; clears bits 1 and 0 |
| stat_q | output | 8 | Status word |
| en_we | input | 1 | Load the enable register |
| en_wdata | input | 8 | New enable value |
| en_q | output | 8 | Enable register |
| buf_clr | input | 1 | Empty the buffer and clear the error flag |
| irq | output | 1 | Masked interrupt, active high |

## Verification
A status read, which clears the complete and error flags, can fall in the same cycle as a fresh event pulse that sets one of them. The bench first raises a flag, then drives `stat_rd` and `done_evt` (or `fail_evt`) together for one cycle. It expects the flag to be set after that edge, and cleared only by a later read that has no event beside it. A write into a full buffer and the clear control are driven in the same way. The bench then checks that the error flag holds until the clear.

// File: rtl/txbuf_irq_status.sv
module txbuf_irq_status #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int RW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          pop_en,
  output logic [DW-1:0] pop_data,
  input  logic [RW-1:0] pkt_remain,
  input  logic          osc_ok,
  input  logic          mon_on,
  input  logic          vbat_low,
  input  logic          done_evt,
  input  logic          fail_evt,
  input  logic          stat_rd,
  output logic [7:0]    stat_q,
  input  logic          en_we,
  input  logic [7:0]    en_wdata,
  output logic [7:0]    en_q,
  input  logic          buf_clr,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] NF_LVL   = CW'(DEPTH - 1);
  localparam logic [CW-1:0] HE_LVL   = CW'(DEPTH / 2);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          osc_q, lv_q, berr, done_f, fail_f;

  wire full   = (cnt == FULL_LVL);
  wire empty  = (cnt == '0);
  wire do_pop = pop_en && !empty;
  wire do_wr  = wr_en && (!full || do_pop);
  wire ovf    = wr_en && full && !do_pop;
  wire unr    = empty && (pkt_remain != '0);

  assign pop_data = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (buf_clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr)  wp <= wp + 1'b1;
      if (do_pop) rp <= rp + 1'b1;
      cnt <= cnt + CW'(do_wr) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr && !buf_clr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      berr   <= 1'b0;
      done_f <= 1'b0;
      fail_f <= 1'b0;
      osc_q  <= 1'b1;
      lv_q   <= 1'b0;
      en_q   <= '0;
    end else begin
      if (buf_clr)         berr <= 1'b0;
      else if (ovf || unr) berr <= 1'b1;
      if (done_evt)     done_f <= 1'b1;
      else if (stat_rd) done_f <= 1'b0;
      if (fail_evt)     fail_f <= 1'b1;
      else if (stat_rd) fail_f <= 1'b0;
      osc_q <= osc_ok;
      lv_q  <= mon_on & vbat_low;
      if (en_we) en_q <= en_wdata;
    end
  end

  assign stat_q = {osc_q, lv_q, (cnt <= NF_LVL), (cnt <= HE_LVL), empty, berr, done_f, fail_f};
  assign irq    = |(stat_q & en_q);
endmodule

// File: rtl/txbuf_irq_status_chk.sv
module txbuf_irq_status_chk #(
  parameter int DEPTH = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_en,
  input logic                         pop_en,
  input logic                         buf_clr,
  input logic                         stat_rd,
  input logic                         done_evt,
  input logic                         fail_evt,
  input logic [$clog2(DEPTH+1)-1:0]   cnt,
  input logic [7:0]                   stat_q,
  input logic [7:0]                   en_q,
  input logic                         irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  a_r4_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pop_en && !buf_clr && cnt == FULL_LVL) |=> (cnt == FULL_LVL && stat_q[2]));

  a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[2] && !buf_clr) |=> stat_q[2]);

  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clr |=> (cnt == '0 && !stat_q[2] && stat_q[3]));

  a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> stat_q[1]);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done_evt && !fail_evt) |=> (stat_q[1:0] == 2'b00));

  a_r8_event_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && fail_evt) |=> stat_q[0]);

  a_r9_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 8'h00) |-> !irq);

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_LVL);
endmodule

bind txbuf_irq_status txbuf_irq_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pop_en(pop_en), .buf_clr(buf_clr),
  .stat_rd(stat_rd), .done_evt(done_evt), .fail_evt(fail_evt), .cnt(cnt),
  .stat_q(stat_q), .en_q(en_q), .irq(irq)
);

// File: tb/txbuf_irq_status_bench.sv
`timescale 1ns/1ps
module txbuf_irq_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, pop_en = 0, osc_ok = 1, mon_on = 0, vbat_low = 0;
  logic done_evt = 0, fail_evt = 0, stat_rd = 0, en_we = 0, buf_clr = 0;
  logic [7:0] wr_data = 0, pkt_remain = 0, en_wdata = 0;
  logic [7:0] pop_data, stat_q, en_q;
  logic irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  txbuf_irq_status u_txbuf_irq_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pop_en(pop_en),
    .pop_data(pop_data), .pkt_remain(pkt_remain), .osc_ok(osc_ok), .mon_on(mon_on),
    .vbat_low(vbat_low), .done_evt(done_evt), .fail_evt(fail_evt), .stat_rd(stat_rd),
    .stat_q(stat_q), .en_we(en_we), .en_wdata(en_wdata), .en_q(en_q),
    .buf_clr(buf_clr), .irq(irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    wr_en = 1; wr_data = b; step(); wr_en = 0;
  endtask

  task automatic pop(output logic [7:0] b);
    b = pop_data; pop_en = 1; step(); pop_en = 0;
  endtask

  task automatic clear();
    buf_clr = 1; step(); buf_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", stat_q, 8'hB8);
    chk("R1 enable", en_q, 8'h00);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_fill_order();
    logic [7:0] b;
    for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
    chk("R3 at 8", stat_q[5:3], 3'b110);
    push(8'h18);
    chk("R3 at 9", stat_q[5:3], 3'b100);
    for (int i = 9; i < 15; i++) push(8'h10 + 8'(i));
    chk("R3 at 15", stat_q[5:3], 3'b100);
    push(8'h1F);
    chk("R3 at 16", stat_q[5:3], 3'b000);
    chk("R4 no error before overflow", stat_q[2], 0);
    push(8'hEE);
    chk("R4 overflow flagged", stat_q[2], 1);
    chk("R4 still full", stat_q[5], 0);
    for (int i = 0; i < 16; i++) begin
      pop(b);
      chk("R2 order / R4 drop", b, 8'h10 + 8'(i));
    end
    chk("R3 empty after drain", stat_q[5:3], 3'b111);
    chk("R6 error sticky", stat_q[2], 1);
    pop(b);
    push(8'h5A);
    chk("R2 pop on empty ignored", pop_data, 8'h5A);
    chk("R2 one byte held", stat_q[3], 0);
    clear();
    chk("R6 clear drops error", stat_q[2], 0);
    chk("R6 clear empties", stat_q[3], 1);
  endtask

  task automatic t_underrun();
    pkt_remain = 8'd3;
    step();
    pkt_remain = 8'd0;
    chk("R5 underrun flagged", stat_q[2], 1);
    step(); step();
    chk("R6 underrun sticky", stat_q[2], 1);
    clear();
    chk("R6 underrun cleared", stat_q[2], 0);
  endtask

  task automatic t_clear_full();
    for (int i = 0; i < 16; i++) push(8'(i));
    wr_en = 1; wr_data = 8'h77; buf_clr = 1; step(); wr_en = 0; buf_clr = 0;
    chk("R6 clear beats write", stat_q[3:2], 2'b10);
    push(8'hC3);
    chk("R6 restart after clear", pop_data, 8'hC3);
    clear();
  endtask

  task automatic t_events();
    done_evt = 1; step(); done_evt = 0;
    chk("R7 done set", stat_q[1], 1);
    step();
    chk("R7 done holds", stat_q[1], 1);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R7 read clears done", stat_q[1], 0);
    fail_evt = 1; step(); fail_evt = 0;
    chk("R7 fail set", stat_q[0], 1);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R7 read clears fail", stat_q[0], 0);
    done_evt = 1; step(); done_evt = 0;
    stat_rd = 1; done_evt = 1; step(); stat_rd = 0; done_evt = 0;
    chk("R8 done wins over read", stat_q[1], 1);
    stat_rd = 1; fail_evt = 1; step(); stat_rd = 0; fail_evt = 0;
    chk("R8 fail wins over read", stat_q[1:0], 2'b01);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R8 later read clears", stat_q[1:0], 2'b00);
  endtask

  task automatic t_irq();
    chk("R9 masked", irq, 0);
    en_we = 1; en_wdata = 8'h02; step(); en_we = 0;
    chk("R9 enable loaded", en_q, 8'h02);
    chk("R9 enabled bit idle", irq, 0);
    chk("R9 bits unmasked view", stat_q, 8'hB8);
    done_evt = 1; step(); done_evt = 0;
    chk("R9 irq on done", irq, 1);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R9 irq drops", irq, 0);
    en_we = 1; en_wdata = 8'h08; step(); en_we = 0;
    chk("R9 irq on empty", irq, 1);
    push(8'h01);
    chk("R9 irq follows level", irq, 0);
    clear();
    en_we = 1; en_wdata = 8'h00; step(); en_we = 0;
  endtask

  task automatic t_monitors();
    vbat_low = 1; mon_on = 0; step();
    chk("R10 low voltage off", stat_q[6], 0);
    mon_on = 1; step();
    chk("R10 low voltage on", stat_q[6], 1);
    vbat_low = 0; step();
    chk("R10 low voltage tracks", stat_q[6], 0);
    osc_ok = 0; step();
    chk("R10 osc low", stat_q[7], 0);
    osc_ok = 1; step();
    chk("R10 osc high", stat_q[7], 1);
    mon_on = 0;
  endtask

  initial begin
    #12;
    rst_n = 1;
    #1;
    t_reset();
    step();
    t_fill_order();
    t_underrun();
    t_clear_full();
    t_events();
    t_irq();
    t_monitors();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule